// File: doc/BRIEF.md
# Frame-Synced Serial Port in SPI Master Mode

This block is a frame-synchronised serial transmitter and receiver held in a stop-clock configuration so that it behaves as an SPI master. The host presents a word together with a one-cycle load strobe. The word moves into a transmit shift register, and the active-low frame-select output drops in the same step. The serial clock is derived from the system clock by a programmable half-period divider. It toggles only while a word is in flight and otherwise rests at the level the polarity input selects.

The receive path has no clock input of its own. It samples the slave's data line on the same internally generated edges that drive the transmit path. Data moves MSB first. A one-bit data delay is fixed, so the first bit is already on the data output when frame-select falls, which gives the slave setup time. When the frame ends, the received word is copied to the receive output and a done strobe pulses for one cycle.

Top module: `bsp_spi_master`

## Requirements
- R1: While reset is held and right after it is released: frame-select is high, busy is 0, done is 0, the received word is 0, the data output is 0, and the serial clock equals the polarity input.
- R2: The 2-bit stop-mode input selects SPI operation. 2'b10 is the no-delay phase and 2'b11 is the delay phase. With 2'b00 or 2'b01, a load strobe is ignored: busy stays 0 and frame-select stays high.
- R3: The serial clock rests at the polarity level (0 = low, 1 = high) outside a frame. It toggles exactly 2*W times per word and ends the frame at the rest level.
- R4: Each serial clock half period lasts divide+1 system clock cycles, for a divide value of 0 to 255. The first clock edge comes divide+1 cycles after the load is accepted.
- R5: Frame-select goes low in the cycle after an accepted load. It stays low through every clock edge and returns high one half period after the last edge.
- R6: The transmit word leaves MSB first. Its MSB is already on the data output in the cycle frame-select falls (fixed one-bit data delay).
- R7: In delay mode (2'b11), data is sampled on odd-numbered clock edges (1st, 3rd, and so on) and changes on even-numbered edges. In no-delay mode (2'b10), the 1st edge launches the MSB, data is sampled on even-numbered edges, and it changes on odd-numbered edges from the 3rd edge on.
- R8: The received word is assembled MSB first. It appears on the receive output together with a one-cycle done pulse, (2*W+1)*(divide+1) cycles after the load was accepted, and it does not change at any other time.
- R9: A load strobe while busy is ignored. The word being sent is not altered.
- R10: Busy is high from the cycle after an accepted load until the cycle done pulses, when it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_stop_mode_i | input | 2 | Stop-clock mode select (2'b10 no delay, 2'b11 delay) |
| cfg_cpol_i | input | 1 | Serial clock rest level |
| cfg_div_i | input | DIV_W | Half-period divide value |
| tx_word_i | input | W | Word to transmit |
| tx_load_i | input | 1 | Load strobe for tx_word_i |
| rx_word_o | output | W | Last received word |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when rx_word_o updates |
| sclk_o | output | 1 | Serial clock |
| fsel_no | output | 1 | Frame select, active low |
| mosi_o | output | 1 | Serial data to slave |
| miso_i | input | 1 | Serial data from slave |

## Verification
Every result is timed from the load edge in system cycles. Busy, frame-select and the MSB are due one edge after the load. Clock edge k is due at k*(divide+1), and done with the new word at (2*W+1)*(divide+1). The bench counts edges from the accepted load, samples every output on the falling system clock edge, and compares each toggle's position and spacing against divide+1. A slave model reacts only to observed clock toggles, so data launch and capture follow the mode's edge numbering and not any fixed cycle guess.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic [1:0] {
    MODE_RUN0  = 2'b00,
    MODE_RUN1  = 2'b01,
    MODE_NODLY = 2'b10,
    MODE_DLY   = 2'b11
  } stop_mode_e;

  function automatic logic is_spi(stop_mode_e m);
    return (m == MODE_NODLY) || (m == MODE_DLY);
  endfunction
endpackage

// File: rtl/bsp_clkdiv.sv
module bsp_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || cnt_q == '0) cnt_q <= div_i;
    else                          cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = run_i && (cnt_q == '0);

  // half period never shorter than the programmed value
  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_o && $past(run_i) |=> !run_i || cnt_q == $past(div_i));
endmodule

// File: rtl/bsp_shifter.sv
module bsp_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  input  logic         sample_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [W-1:0] rx_o
);
  logic [W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= data_i;
      rx_q <= '0;
    end else begin
      if (shift_i)  tx_q <= {tx_q[W-2:0], 1'b0};
      if (sample_i) rx_q <= {rx_q[W-2:0], miso_i};
    end
  end

  assign mosi_o = tx_q[W-1];
  assign rx_o   = rx_q;

  p_load_alone_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !shift_i && !sample_i);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !shift_i |=> $stable(mosi_o));
endmodule

// File: rtl/bsp_spi_master.sv
module bsp_spi_master
  import bsp_pkg::*;
#(
  parameter int W     = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cfg_stop_mode_i,
  input  logic             cfg_cpol_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic [W-1:0]     tx_word_i,
  input  logic             tx_load_i,
  output logic [W-1:0]     rx_word_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sclk_o,
  output logic             fsel_no,
  output logic             mosi_o,
  input  logic             miso_i
);
  localparam int EDGES = 2 * W;
  localparam int CNT_W = $clog2(EDGES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES);

  logic             busy_q, done_q, sclk_q, dly_q, cpol_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] edge_q;
  logic [W-1:0]     rx_word_q, rx_sr;
  logic             load_go, tick, in_edges, sample_go, shift_go, finish;

  assign load_go  = tx_load_i && !busy_q && is_spi(stop_mode_e'(cfg_stop_mode_i));
  assign in_edges = busy_q && (edge_q < LAST);
  // delay mode: capture on even index (1st,3rd..), else odd index
  assign sample_go = tick && in_edges && (dly_q ? !edge_q[0] : edge_q[0]);
  assign shift_go  = tick && in_edges &&
                     (dly_q ? edge_q[0] : (!edge_q[0] && edge_q != '0));
  assign finish    = tick && busy_q && (edge_q == LAST);

  bsp_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .div_i  (busy_q ? div_q : cfg_div_i),
    .tick_o (tick)
  );

  bsp_shifter #(.W(W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_go),
    .data_i   (tx_word_i),
    .shift_i  (shift_go),
    .sample_i (sample_go),
    .miso_i   (miso_i),
    .mosi_o   (mosi_o),
    .rx_o     (rx_sr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      sclk_q    <= 1'b0;
      dly_q     <= 1'b0;
      cpol_q    <= 1'b0;
      div_q     <= '0;
      edge_q    <= '0;
      rx_word_q <= '0;
    end else begin
      done_q <= finish;
      if (load_go) begin
        busy_q <= 1'b1;
        dly_q  <= cfg_stop_mode_i[0];
        cpol_q <= cfg_cpol_i;
        sclk_q <= cfg_cpol_i;
        div_q  <= cfg_div_i;
        edge_q <= '0;
      end else if (finish) begin
        busy_q    <= 1'b0;
        rx_word_q <= rx_sr;
      end else if (tick && in_edges) begin
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign fsel_no   = ~busy_q;
  assign sclk_o    = busy_q ? sclk_q : cfg_cpol_i;
  assign rx_word_o = rx_word_q;

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_rx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rx_word_o));
  p_off_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_i && !busy_o && !cfg_stop_mode_i[1] |=> !busy_o);
  p_idle_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(sclk_q) == cpol_q);
  p_edge_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> edge_q <= LAST);
  p_done_ends_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
endmodule

// File: tb/bsp_spi_master_test.sv
module bsp_spi_master_test;
  localparam int W = 8;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode = 2'b10;
  logic cpol = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic [W-1:0] tx_word = '0;
  logic tx_load = 1'b0;
  logic miso = 1'b0;
  logic [W-1:0] rx_word;
  logic busy, done, sclk, fsel_n, mosi;

  int errors = 0, checks = 0, cyc = 0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc++;

  bsp_spi_master #(.W(W), .DIV_W(DIV_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_stop_mode_i(mode), .cfg_cpol_i(cpol),
    .cfg_div_i(div), .tx_word_i(tx_word), .tx_load_i(tx_load),
    .rx_word_o(rx_word), .busy_o(busy), .done_o(done), .sclk_o(sclk),
    .fsel_no(fsel_n), .mosi_o(mosi), .miso_i(miso)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // fields: dly, cpol, div[7:0], tx[7:0], rx[7:0]
  localparam logic [25:0] VECS [0:5] = '{
    {1'b1, 1'b0, 8'd1, 8'hA5, 8'h3C},
    {1'b0, 1'b0, 8'd1, 8'h5A, 8'hC3},
    {1'b1, 1'b1, 8'd2, 8'h81, 8'h7E},
    {1'b0, 1'b1, 8'd3, 8'hF0, 8'h0F},
    {1'b1, 1'b0, 8'd4, 8'h00, 8'hFF},
    {1'b0, 1'b1, 8'd0, 8'hFF, 8'h00}
  };

  task automatic run_xfer(input logic dly, input logic pol, input logic [7:0] dv,
                          input logic [7:0] tx, input logic [7:0] rx, input bit poke);
    int n, tog, last, bit_i, gap_bad, fsel_bad;
    logic prev;
    logic [7:0] cap;
    mode = dly ? 2'b11 : 2'b10;
    cpol = pol; div = dv; tx_word = tx; tx_load = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_load = 1'b0;
    chk(busy == 1'b1, "R10 busy after load", 32'(busy), 1);
    chk(fsel_n == 1'b0, "R5 fsel low after load", 32'(fsel_n), 0);
    chk(mosi == tx[7], "R6 msb preset", 32'(mosi), 32'(tx[7]));
    chk(sclk == pol, "R3 rest level at start", 32'(sclk), 32'(pol));
    n = 0; tog = 0; last = 0; bit_i = 0; gap_bad = 0; fsel_bad = 0;
    prev = pol; cap = '0; miso = rx[7];
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 2) begin tx_word = ~tx; tx_load = 1'b1; end
      if (poke && n == 3) tx_load = 1'b0;
      if (!done && fsel_n) fsel_bad++;
      if (sclk != prev) begin
        tog++;
        if (n - last != int'(dv) + 1) gap_bad++;
        last = n; prev = sclk;
        if (dly ? tog[0] : !tog[0]) cap = {cap[6:0], mosi};
        else if (dly || tog >= 3) begin
          bit_i++;
          if (bit_i < 8) miso = rx[7 - bit_i];
        end
      end
    end
    chk(n == 17 * (int'(dv) + 1), "R8 done timing", 32'(n), 32'(17 * (int'(dv) + 1)));
    chk(tog == 16, "R3 toggle count", 32'(tog), 16);
    chk(gap_bad == 0, "R4 half period", 32'(gap_bad), 0);
    chk(fsel_bad == 0, "R5 fsel held low", 32'(fsel_bad), 0);
    chk(fsel_n == 1'b1, "R5 fsel released", 32'(fsel_n), 1);
    chk(sclk == pol, "R3 rest level at end", 32'(sclk), 32'(pol));
    chk(cap == tx, poke ? "R9 busy load ignored" : "R7 mosi stream", 32'(cap), 32'(tx));
    chk(rx_word == rx, "R7 R8 rx word", 32'(rx_word), 32'(rx));
    chk(busy == 1'b0, "R10 busy cleared", 32'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single pulse", 32'(done), 0);
    chk(rx_word == rx, "R8 rx held", 32'(rx_word), 32'(rx));
  endtask

  initial begin
    wait (cyc == 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    chk(fsel_n == 1'b1 && busy == 1'b0 && done == 1'b0, "R1 reset outputs", {fsel_n, busy, done}, 3'b100);
    chk(sclk == 1'b1, "R1 reset clock level", 32'(sclk), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rx_word == '0 && mosi == 1'b0, "R1 rx and mosi after reset", {rx_word, mosi}, 0);

    foreach (VECS[i]) begin
      run_xfer(VECS[i][25], VECS[i][24], VECS[i][23:16], VECS[i][15:8], VECS[i][7:0], 1'b0);
      repeat (2) @(negedge clk);
    end

    // R9: load strobe mid-frame
    run_xfer(1'b1, 1'b0, 8'd2, 8'hC6, 8'h95, 1'b1);
    // back-to-back right after done, no gap cycles
    run_xfer(1'b0, 1'b0, 8'd1, 8'h39, 8'h6B, 1'b0);
    // R4 largest divide value
    run_xfer(1'b1, 1'b1, 8'd255, 8'h96, 8'hA3, 1'b0);

    // R2 non-SPI modes ignore load
    for (int m = 0; m < 2; m++) begin
      mode = 2'(m); cpol = 1'b0; tx_word = 8'h77; tx_load = 1'b1;
      @(negedge clk);
      tx_load = 1'b0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(busy == 1'b0 && fsel_n == 1'b1 && sclk == 1'b0, "R2 off mode ignored",
            {busy, fsel_n, sclk}, 3'b010);
      end
      chk(rx_word == 8'hA3, "R2 rx untouched", 32'(rx_word), 32'hA3);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule